// File: doc/BRIEF.md
# Time-Slot Connection Command Checker

This block keeps the connection table of a time-slot switch and screens every change a host makes to it. Each command either establishes or releases one connection. A connection names an output port (time-slot and line), an input port (time-slot and line) and a connection type: minimum delay, constant delay or message. The block checks each command against the table and writes the table only when the command is legal. An illegal command leaves every stored connection as it was, so switching carries on undisturbed.

A rejected command sets a sticky interrupt flag, and the flag stays set until the host clears it. The opcode and output port of the most recent rejected command are kept in an error capture register. A full table raises the same flag as a programming error. The frame data path reads the table through a combinational lookup port, and the bench uses the same port to observe the table.

Changing a connection takes two commands: the host releases the old connection and then establishes the new one. No command overwrites an entry in place.

Top module: `tsw_conn_cmd_chk`

## Requirements
- R1: After reset the table is empty, `irq` is 0, `rsp_valid` is 0, the error capture holds zeros and `cmd_ready` is 1.
- R2: An establish (`cmd_op`=0) whose output port has no connection, with type 0 (minimum delay), 1 (constant delay) or 2 (message), is accepted when a free entry exists. After that, the lookup port reports its input port and type.
- R3: A release (`cmd_op`=1) whose output port, input port and type all match a stored connection is accepted. After that, the lookup port misses on that output port.
- R4: A release that matches no stored connection is rejected: the output port is absent, or the input port differs, or the type differs. The table is left unchanged.
- R5: An establish of a minimum-delay connection that already exists is rejected, and the stored connection is kept.
- R6: An establish of a constant-delay or message connection on an output port already in use is rejected, and the stored connection is kept.
- R7: An establish while all NUM_ENTRIES entries are in use is rejected as an overflow, and `irq` is set.
- R8: Every rejection sets `irq`. `irq` stays set until an `irq_clr` pulse clears it. If a rejection and `irq_clr` occur in the same cycle, `irq` stays set.
- R9: On a rejection, `err_op`, `err_dst_slot` and `err_dst_line` capture the rejected command. Accepted commands leave them unchanged.
- R10: A command with type code 3 is rejected for both establish and release.
- R11: `rsp_valid` is high for exactly one cycle, the cycle after each handshake (`cmd_valid` and `cmd_ready` both high at a clock edge). `rsp_ok` gives the verdict in that cycle.
- R12: An entry freed by a release can be used again, so the release-then-establish sequence replaces the connection on an output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 1 | 0 establish, 1 release |
| cmd_dst_slot | input | 5 | Output time-slot |
| cmd_dst_line | input | 3 | Output line |
| cmd_src_slot | input | 5 | Input time-slot |
| cmd_src_line | input | 3 | Input line |
| cmd_type | input | 2 | 0 minimum delay, 1 constant delay, 2 message, 3 reserved |
| rsp_valid | output | 1 | Verdict strobe, one cycle after the handshake |
| rsp_ok | output | 1 | 1 when the command was applied |
| irq | output | 1 | Sticky error and overflow flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| err_op | output | 1 | Opcode of the last rejected command |
| err_dst_slot | output | 5 | Output time-slot of the last rejected command |
| err_dst_line | output | 3 | Output line of the last rejected command |
| map_slot | input | 5 | Lookup output time-slot |
| map_line | input | 3 | Lookup output line |
| map_hit | output | 1 | A connection exists on the looked-up port |
| map_src_slot | output | 5 | Input time-slot of that connection, 0 on a miss |
| map_src_line | output | 3 | Input line of that connection, 0 on a miss |
| map_type | output | 2 | Type of that connection, 0 on a miss |

## Verification
The embedded properties check, on every cycle, that no output port is ever held by two entries. They also check that a rejected command leaves the used-entry set unchanged, and that an accepted establish or release changes the entry count by exactly one. Further properties cover the response strobe following each handshake, the interrupt being set after every rejection, and the interrupt holding until it is cleared. Table writes are checked to land only on free or occupied entries, as the operation requires. The directed scenarios show the rest, which no single-cycle property can: which specific commands are legal, what the error capture holds, overflow at exactly a full table, and the replacement of a connection by release then establish.

// File: rtl/tsw_conn_pkg.sv
// Shared widths, encodings and the table entry layout for the
// connection command checker. Assumes 32 time-slots and 8 lines per port.
package tsw_conn_pkg;
    localparam int SLOT_W = 5;
    localparam int LINE_W = 3;

    typedef enum logic {
        OP_EST = 1'b0,
        OP_REL = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        CT_MIN   = 2'd0,
        CT_CONST = 2'd1,
        CT_MSG   = 2'd2,
        CT_RSVD  = 2'd3
    } ctype_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [LINE_W-1:0] line;
    } port_t;

    typedef struct packed {
        logic   used;
        port_t  dst;
        port_t  src;
        ctype_e ctype;
    } entry_t;
endpackage

// File: rtl/tsw_conn_table.sv
// Connection storage: ENTRIES registers written one at a time.
// Assumes the caller writes used=1 only to a free entry and used=0 only
// to an occupied one; all entries are read in parallel.
module tsw_conn_table
    import tsw_conn_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data,
    output entry_t           tbl_o [ENTRIES]
);

    entry_t tbl_q [ENTRIES];

    // Clear all entries on reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= '0;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_data;
        end
    end

    assign tbl_o = tbl_q;

    // R12: an establish only lands on a free entry.
    a_r12_est_on_free: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data.used |-> !tbl_q[wr_idx].used);

    // R3: a release only clears an occupied entry.
    a_r3_rel_on_used: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data.used |-> tbl_q[wr_idx].used);

endmodule

// File: rtl/tsw_conn_match.sv
// Parallel output-port comparator: flags each occupied entry whose
// output port equals the key. Purely combinational.
module tsw_conn_match
    import tsw_conn_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  entry_t               tbl_i [ENTRIES],
    input  port_t                key,
    output logic [ENTRIES-1:0]   hit
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // One comparator per entry.
        assign hit[g] = tbl_i[g].used && (tbl_i[g].dst == key);
    end

endmodule

// File: rtl/tsw_conn_pick.sv
// Priority encoder: returns the lowest set bit of req and whether any
// bit is set. Assumes WIDTH >= 2.
module tsw_conn_pick #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest request wins.
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/tsw_conn_cmd_chk.sv
// Connection command checker: validates establish/release commands
// against the connection table, applies legal ones in the handshake
// cycle, flags illegal ones through a sticky interrupt and captures them.
// Assumes one command per cycle at most; cmd_ready is high after reset.
module tsw_conn_cmd_chk
    import tsw_conn_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [SLOT_W-1:0] cmd_dst_slot,
    input  logic [LINE_W-1:0] cmd_dst_line,
    input  logic [SLOT_W-1:0] cmd_src_slot,
    input  logic [LINE_W-1:0] cmd_src_line,
    input  logic [1:0]        cmd_type,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              irq,
    input  logic              irq_clr,
    output logic              err_op,
    output logic [SLOT_W-1:0] err_dst_slot,
    output logic [LINE_W-1:0] err_dst_line,
    input  logic [SLOT_W-1:0] map_slot,
    input  logic [LINE_W-1:0] map_line,
    output logic              map_hit,
    output logic [SLOT_W-1:0] map_src_slot,
    output logic [LINE_W-1:0] map_src_line,
    output logic [1:0]        map_type
);

    entry_t               tbl [NUM_ENTRIES];
    port_t                key_dst, key_src, key_map;
    logic [NUM_ENTRIES-1:0] dst_hit, full_hit, free_vec, map_vec, used_vec;
    logic [IDX_W-1:0]     free_idx, rel_idx, map_idx;
    logic                 free_any, rel_any;
    logic                 cmd_fire, cmd_ok, type_ok, is_rel;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    entry_t               wr_data;
    logic                 ready_q, rsp_valid_q, rsp_ok_q, irq_q, err_op_q;
    port_t                err_dst_q;

    assign key_dst  = '{slot: cmd_dst_slot, line: cmd_dst_line};
    assign key_src  = '{slot: cmd_src_slot, line: cmd_src_line};
    assign key_map  = '{slot: map_slot, line: map_line};
    assign cmd_fire = cmd_valid && ready_q;
    assign type_ok  = (cmd_type != CT_RSVD);
    assign is_rel   = (cmd_op == OP_REL);

    tsw_conn_table #(.ENTRIES(NUM_ENTRIES)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .tbl_o  (tbl)
    );

    tsw_conn_match #(.ENTRIES(NUM_ENTRIES)) cmd_match_i (
        .tbl_i(tbl),
        .key  (key_dst),
        .hit  (dst_hit)
    );

    tsw_conn_match #(.ENTRIES(NUM_ENTRIES)) map_match_i (
        .tbl_i(tbl),
        .key  (key_map),
        .hit  (map_vec)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vec
        // Exact-connection match for release, free and used flags.
        assign full_hit[g] = dst_hit[g] && (tbl[g].src == key_src)
                             && (tbl[g].ctype == ctype_e'(cmd_type));
        assign free_vec[g] = !tbl[g].used;
        assign used_vec[g] = tbl[g].used;
    end

    tsw_conn_pick #(.WIDTH(NUM_ENTRIES)) free_pick_i (
        .req(free_vec), .idx(free_idx), .any(free_any)
    );

    tsw_conn_pick #(.WIDTH(NUM_ENTRIES)) rel_pick_i (
        .req(full_hit), .idx(rel_idx), .any(rel_any)
    );

    tsw_conn_pick #(.WIDTH(NUM_ENTRIES)) map_pick_i (
        .req(map_vec), .idx(map_idx), .any(map_hit)
    );

    // Decide the verdict and the table write for the current command.
    always_comb begin
        wr_data = '0;
        if (is_rel) begin
            cmd_ok = type_ok && rel_any;
            wr_idx = rel_idx;
        end else begin
            cmd_ok        = type_ok && !(|dst_hit) && free_any;
            wr_idx        = free_idx;
            wr_data.used  = 1'b1;
            wr_data.dst   = key_dst;
            wr_data.src   = key_src;
            wr_data.ctype = ctype_e'(cmd_type);
        end
        wr_en = cmd_fire && cmd_ok;
    end

    // Handshake readiness and the one-cycle verdict strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_ok_q    <= 1'b0;
        end else begin
            ready_q     <= 1'b1;
            rsp_valid_q <= cmd_fire;
            rsp_ok_q    <= cmd_fire && cmd_ok;
        end
    end

    // Sticky interrupt: a rejection sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (cmd_fire && !cmd_ok) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    // Capture opcode and output port of each rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_op_q  <= 1'b0;
            err_dst_q <= '0;
        end else if (cmd_fire && !cmd_ok) begin
            err_op_q  <= cmd_op;
            err_dst_q <= key_dst;
        end
    end

    assign cmd_ready    = ready_q;
    assign rsp_valid    = rsp_valid_q;
    assign rsp_ok       = rsp_ok_q;
    assign irq          = irq_q;
    assign err_op       = err_op_q;
    assign err_dst_slot = err_dst_q.slot;
    assign err_dst_line = err_dst_q.line;
    assign map_src_slot = map_hit ? tbl[map_idx].src.slot : '0;
    assign map_src_line = map_hit ? tbl[map_idx].src.line : '0;
    assign map_type     = map_hit ? tbl[map_idx].ctype : 2'd0;

    // R5, R6: an output port is never held by two entries.
    a_r5_unique_dst: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_hit));

    // R4: a rejected command leaves the occupied set untouched.
    a_r4_reject_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && !cmd_ok |=> $stable(used_vec));

    // R2: an accepted establish adds exactly one entry.
    a_r2_est_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && cmd_ok && !is_rel |=>
        $countones(used_vec) == $past($countones(used_vec)) + 1);

    // R3: an accepted release removes exactly one entry.
    a_r3_rel_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && cmd_ok && is_rel |=>
        $countones(used_vec) + 1 == $past($countones(used_vec)));

    // R8: a negative verdict is always accompanied by the flag.
    a_r8_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok |-> irq);

    // R8: the flag holds until cleared.
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

    // R11: the verdict strobe follows each handshake and nothing else.
    a_r11_rsp_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> rsp_valid);
    a_r11_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_fire |=> !rsp_valid);

endmodule

// File: tb/tsw_conn_cmd_chk_tb_top.sv
// Directed bench for the connection command checker.
module tsw_conn_cmd_chk_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_op = 1'b0;
    logic [4:0] cmd_dst_slot = '0;
    logic [2:0] cmd_dst_line = '0;
    logic [4:0] cmd_src_slot = '0;
    logic [2:0] cmd_src_line = '0;
    logic [1:0] cmd_type = '0;
    logic       rsp_valid, rsp_ok, irq;
    logic       irq_clr = 1'b0;
    logic       err_op;
    logic [4:0] err_dst_slot;
    logic [2:0] err_dst_line;
    logic [4:0] map_slot = '0;
    logic [2:0] map_line = '0;
    logic       map_hit;
    logic [4:0] map_src_slot;
    logic [2:0] map_src_line;
    logic [1:0] map_type;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    tsw_conn_cmd_chk dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_dst_slot(cmd_dst_slot), .cmd_dst_line(cmd_dst_line),
        .cmd_src_slot(cmd_src_slot), .cmd_src_line(cmd_src_line),
        .cmd_type(cmd_type), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .irq(irq), .irq_clr(irq_clr), .err_op(err_op),
        .err_dst_slot(err_dst_slot), .err_dst_line(err_dst_line),
        .map_slot(map_slot), .map_line(map_line), .map_hit(map_hit),
        .map_src_slot(map_src_slot), .map_src_line(map_src_line),
        .map_type(map_type)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Issue one command and check its verdict in the cycle after the handshake.
    task automatic send(input logic op, input logic [4:0] ds, input logic [2:0] dl,
                        input logic [4:0] ss, input logic [2:0] sl, input logic [1:0] ty,
                        input bit exp_ok, input string tag);
        @(negedge clk);
        cmd_op = op; cmd_dst_slot = ds; cmd_dst_line = dl;
        cmd_src_slot = ss; cmd_src_line = sl; cmd_type = ty; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(int'(rsp_valid), 1, tag, "rsp_valid");
        chk(int'(rsp_ok), int'(exp_ok), tag, "rsp_ok");
    endtask

    task automatic look(input logic [4:0] ds, input logic [2:0] dl, input bit hit,
                        input int ss, input int sl, input int ty, input string tag);
        @(negedge clk);
        map_slot = ds; map_line = dl;
        #1;
        chk(int'(map_hit), int'(hit), tag, "map_hit");
        chk(int'(map_src_slot), ss, tag, "map_src_slot");
        chk(int'(map_src_line), sl, tag, "map_src_line");
        chk(int'(map_type), ty, tag, "map_type");
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk(int'(irq), 0, "R8", "irq after clear");
    endtask

    task automatic t_reset();
        chk(int'(cmd_ready), 1, "R1", "cmd_ready");
        chk(int'(rsp_valid), 0, "R1", "rsp_valid");
        chk(int'(irq), 0, "R1", "irq");
        chk(int'(err_op), 0, "R1", "err_op");
        chk(int'(err_dst_slot), 0, "R1", "err_dst_slot");
        look(5'd0, 3'd0, 1'b0, 0, 0, 0, "R1");
        look(5'd31, 3'd7, 1'b0, 0, 0, 0, "R1");
    endtask

    task automatic t_establish_types();
        send(1'b0, 5'd3, 3'd1, 5'd7, 3'd2, 2'd0, 1'b1, "R2");
        @(negedge clk);
        chk(int'(rsp_valid), 0, "R11", "strobe single cycle");
        send(1'b0, 5'd4, 3'd0, 5'd9, 3'd5, 2'd1, 1'b1, "R2");
        send(1'b0, 5'd5, 3'd7, 5'd1, 3'd1, 2'd2, 1'b1, "R2");
        look(5'd3, 3'd1, 1'b1, 7, 2, 0, "R2");
        look(5'd4, 3'd0, 1'b1, 9, 5, 1, "R2");
        look(5'd5, 3'd7, 1'b1, 1, 1, 2, "R2");
        chk(int'(irq), 0, "R2", "irq after legal commands");
        chk(int'(err_dst_slot), 0, "R9", "capture untouched by accepts");
    endtask

    task automatic t_release_absent();
        send(1'b1, 5'd10, 3'd0, 5'd7, 3'd2, 2'd0, 1'b0, "R4");
        chk(int'(irq), 1, "R8", "irq after bad release");
        chk(int'(err_op), 1, "R9", "err_op");
        chk(int'(err_dst_slot), 10, "R9", "err_dst_slot");
        send(1'b1, 5'd3, 3'd1, 5'd8, 3'd2, 2'd0, 1'b0, "R4");
        send(1'b1, 5'd3, 3'd1, 5'd7, 3'd2, 2'd1, 1'b0, "R4");
        chk(int'(err_dst_slot), 3, "R9", "err_dst_slot");
        chk(int'(err_dst_line), 1, "R9", "err_dst_line");
        look(5'd3, 3'd1, 1'b1, 7, 2, 0, "R4");
        @(negedge clk);
        chk(int'(irq), 1, "R8", "irq held");
        clear_irq();
    endtask

    task automatic t_duplicates();
        send(1'b0, 5'd3, 3'd1, 5'd7, 3'd2, 2'd0, 1'b0, "R5");
        chk(int'(err_op), 0, "R9", "err_op establish");
        look(5'd3, 3'd1, 1'b1, 7, 2, 0, "R5");
        send(1'b0, 5'd3, 3'd1, 5'd11, 3'd3, 2'd1, 1'b0, "R6");
        send(1'b0, 5'd4, 3'd0, 5'd2, 3'd2, 2'd2, 1'b0, "R6");
        chk(int'(err_dst_slot), 4, "R9", "err_dst_slot");
        look(5'd4, 3'd0, 1'b1, 9, 5, 1, "R6");
        look(5'd3, 3'd1, 1'b1, 7, 2, 0, "R6");
        clear_irq();
    endtask

    task automatic t_reserved();
        send(1'b0, 5'd20, 3'd2, 5'd1, 3'd1, 2'd3, 1'b0, "R10");
        look(5'd20, 3'd2, 1'b0, 0, 0, 0, "R10");
        send(1'b1, 5'd5, 3'd7, 5'd1, 3'd1, 2'd3, 1'b0, "R10");
        look(5'd5, 3'd7, 1'b1, 1, 1, 2, "R10");
        clear_irq();
    endtask

    task automatic t_irq_race();
        @(negedge clk);
        cmd_op = 1'b1; cmd_dst_slot = 5'd30; cmd_dst_line = 3'd3;
        cmd_src_slot = '0; cmd_src_line = '0; cmd_type = 2'd0;
        cmd_valid = 1'b1; irq_clr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; irq_clr = 1'b0;
        chk(int'(rsp_ok), 0, "R8", "race verdict");
        chk(int'(irq), 1, "R8", "set wins over clear");
        clear_irq();
    endtask

    task automatic t_change();
        send(1'b1, 5'd3, 3'd1, 5'd7, 3'd2, 2'd0, 1'b1, "R3");
        look(5'd3, 3'd1, 1'b0, 0, 0, 0, "R3");
        send(1'b0, 5'd3, 3'd1, 5'd12, 3'd4, 2'd1, 1'b1, "R12");
        look(5'd3, 3'd1, 1'b1, 12, 4, 1, "R12");
        chk(int'(irq), 0, "R3", "no flag on legal change");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 29; i++) begin
            send(1'b0, 5'(i), 3'd6, 5'(i), 3'd0, 2'd1, 1'b1, "R7");
        end
        chk(int'(irq), 0, "R7", "irq before full");
        send(1'b0, 5'd29, 3'd6, 5'd0, 3'd0, 2'd0, 1'b0, "R7");
        chk(int'(irq), 1, "R7", "irq on overflow");
        chk(int'(err_dst_slot), 29, "R7", "err_dst_slot");
        chk(int'(err_dst_line), 6, "R7", "err_dst_line");
        look(5'd29, 3'd6, 1'b0, 0, 0, 0, "R7");
        send(1'b1, 5'd0, 3'd6, 5'd0, 3'd0, 2'd1, 1'b1, "R12");
        send(1'b0, 5'd29, 3'd6, 5'd2, 3'd1, 2'd2, 1'b1, "R12");
        look(5'd29, 3'd6, 1'b1, 2, 1, 2, "R12");
        clear_irq();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_establish_types();
        t_release_absent();
        t_duplicates();
        t_reserved();
        t_irq_race();
        t_change();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule